// File: doc/BRIEF.md
# SPI Shift Program Engine

This block runs one single-line SPI transaction of a programmable length, up to 56 clock periods, against a serial flash or any other SPI target. Software first fills six transmit byte registers and a bit-count register over a simple byte-wide register bus. It then sets the start bit in the command register. The engine drives chip select low and toggles the serial clock once per counted bit. It shifts the transmit bytes out MSB first and captures the incoming line into an 80-bit receive chain. It then releases chip select and clears the busy bit by itself.

The transmit byte with the highest index goes out first. Once the 48 loaded bits are spent, the output line carries zeros, so unused positions idle low. The receive chain shifts toward higher byte indices, so receive byte 0 always holds the most recent eight sampled bits. A bit count one larger than a whole number of bytes adds one extra clock before the data that is sampled. The serial clock runs at the system clock divided by twice `HALF_DIV`.

Register map (byte addresses): transmit bytes 0..5 at 0..5, bit count at 6, command at 7, receive bytes 0..9 at 16..25. Other addresses read as zero.

Top module: `spi_prog_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock and the output line are low, the busy bit reads 0, and the transmit bytes, the bit count and all receive bytes read 0.
- R2: Bits go out MSB first, starting with transmit byte 5 and continuing down to byte 0. Every bit past the 48th is 0.
- R3: The transaction has exactly as many serial clock periods as the stored bit count. A write of a value above 56 to the bit-count register stores 56, and the register reads back the stored value.
- R4: Writing the command register with bit 2 set, while idle and with a nonzero count, makes bit 2 of the command register read 1 from the next cycle. Bit 2 clears itself exactly 2·HALF_DIV·count cycles after that write edge.
- R5: The clock idles low. The output line changes only together with a falling clock edge, and the input line is sampled on the rising clock edge.
- R6: The receive chain is cleared at start. Each sampled bit enters bit 0 of the chain as the chain shifts left by one. Receive byte i reads chain bits 8i+7..8i, so byte 0 holds the last eight sampled bits, with the first of them sampled in bit 7.
- R7: A start with a bit count of 0 completes at once: chip select stays high and bit 2 of the command register stays 0.
- R8: While busy, writes to the transmit bytes, the bit count and the command register are ignored.
- R9: Chip select is low for the whole transaction and high otherwise. The output line is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | ADDR_W | Register byte address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |

## Verification
A register write takes effect on the clock edge that samples the strobe. The busy bit is therefore read one step after that edge, and it must then read 1. The bench counts edges from the start edge and expects busy to fall on edge 2·HALF_DIV·count exactly, not on any earlier or later edge. All other results are read only after busy has cleared: the captured output bit stream, the number of serial clocks, and the receive bytes. The bench samples outputs one nanosecond after each edge, and the target model it contains moves its data only on falling serial clock edges.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned START_BIT = 2;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_TX,
        REG_CNT,
        REG_CMD,
        REG_RX
    } reg_kind_e;

endpackage

// File: rtl/spi_prog_clkgen.sv
module spi_prog_clkgen #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && (s_q.cnt == DIV_W'(HALF_DIV - 1));
        if (restart || !run) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spi_prog_ctrl.sv
module spi_prog_ctrl #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_load,
    input  logic             tick,
    output logic             busy,
    output logic             sclk,
    output logic             cs_n,
    output logic             sample,
    output logic             shift_en
);
    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic [CNT_W-1:0] remain;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        sample   = 1'b0;
        shift_en = 1'b0;
        if (start) begin
            s_d.busy   = 1'b1;
            s_d.sclk   = 1'b0;
            s_d.remain = cnt_load;
        end else if (s_q.busy && tick) begin
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
                sample   = 1'b1;
            end else begin
                s_d.sclk   = 1'b0;
                shift_en   = 1'b1;
                s_d.remain = s_q.remain - CNT_W'(1);
                if (s_q.remain == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign sclk = s_q.sclk;
    assign cs_n = ~s_q.busy;
endmodule

// File: rtl/spi_prog_txshift.sv
module spi_prog_txshift #(
    parameter int unsigned TX_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_data,
    input  logic            shift_en,
    input  logic            active,
    output logic            mosi
);
    typedef struct packed {
        logic [TX_W-1:0] sr;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sr = load_data;
        end else if (shift_en) begin
            s_d.sr = {s_q.sr[TX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mosi = active & s_q.sr[TX_W-1];
endmodule

// File: rtl/spi_prog_rxchain.sv
module spi_prog_rxchain #(
    parameter int unsigned RX_W = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            sample,
    input  logic            miso,
    output logic [RX_W-1:0] chain
);
    typedef struct packed {
        logic [RX_W-1:0] chain;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.chain = '0;
        end else if (sample) begin
            s_d.chain = {s_q.chain[RX_W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign chain = s_q.chain;
endmodule

// File: rtl/spi_prog_engine.sv
module spi_prog_engine
    import spi_prog_pkg::*;
#(
    parameter int unsigned TX_BYTES = 6,
    parameter int unsigned RX_BYTES = 10,
    parameter int unsigned MAX_BITS = 56,
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned CNT_ADDR = 6,
    parameter int unsigned CMD_ADDR = 7,
    parameter int unsigned RX_BASE  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int unsigned TX_W  = TX_BYTES * BYTE_W;
    localparam int unsigned RX_W  = RX_BYTES * BYTE_W;
    localparam int unsigned CNT_W = $clog2(MAX_BITS + 1);
    localparam int unsigned TXI_W = $clog2(TX_BYTES);
    localparam int unsigned RXI_W = $clog2(RX_BYTES);

    typedef struct packed {
        logic [TX_BYTES-1:0][BYTE_W-1:0] tx;
        logic [CNT_W-1:0]                cnt;
    } regs_t;

    regs_t                           r_d, r_q;
    reg_kind_e                       kind;
    logic [TXI_W-1:0]                tx_idx;
    logic [RXI_W-1:0]                rx_idx;
    logic                            busy;
    logic                            start;
    logic                            tick;
    logic                            sample;
    logic                            shift_en;
    logic [RX_BYTES-1:0][BYTE_W-1:0] rx_bytes;
    logic [CNT_W-1:0]                cnt_cfg;

    // address decode
    always_comb begin
        kind   = REG_NONE;
        tx_idx = host_addr[TXI_W-1:0];
        rx_idx = RXI_W'(host_addr - ADDR_W'(RX_BASE));
        if (host_addr < ADDR_W'(TX_BYTES)) begin
            kind = REG_TX;
        end else if (host_addr == ADDR_W'(CNT_ADDR)) begin
            kind = REG_CNT;
        end else if (host_addr == ADDR_W'(CMD_ADDR)) begin
            kind = REG_CMD;
        end else if ((host_addr >= ADDR_W'(RX_BASE)) &&
                     (host_addr < ADDR_W'(RX_BASE + RX_BYTES))) begin
            kind = REG_RX;
        end
    end

    // register writes, frozen while a transaction runs
    always_comb begin
        r_d = r_q;
        if (host_we && !busy) begin
            case (kind)
                REG_TX:  r_d.tx[tx_idx] = host_wdata;
                REG_CNT: begin
                    if (32'(host_wdata) > MAX_BITS) r_d.cnt = CNT_W'(MAX_BITS);
                    else                            r_d.cnt = CNT_W'(host_wdata);
                end
                default: ;
            endcase
        end
    end

    assign start = host_we && !busy && (kind == REG_CMD) &&
                   host_wdata[START_BIT] && (r_q.cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cnt_cfg = r_q.cnt;

    // read mux
    always_comb begin
        host_rdata = '0;
        case (kind)
            REG_TX:  host_rdata = r_q.tx[tx_idx];
            REG_CNT: host_rdata = BYTE_W'(r_q.cnt);
            REG_CMD: host_rdata[START_BIT] = busy;
            REG_RX:  host_rdata = rx_bytes[rx_idx];
            default: host_rdata = '0;
        endcase
    end

    spi_prog_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (start),
        .tick    (tick)
    );

    spi_prog_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cnt_load (r_q.cnt),
        .tick     (tick),
        .busy     (busy),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .sample   (sample),
        .shift_en (shift_en)
    );

    spi_prog_txshift #(.TX_W(TX_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_data (r_q.tx),
        .shift_en  (shift_en),
        .active    (busy),
        .mosi      (spi_mosi)
    );

    spi_prog_rxchain #(.RX_W(RX_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .sample (sample),
        .miso   (spi_miso),
        .chain  (rx_bytes)
    );
endmodule

// File: rtl/spi_prog_chk.sv
module spi_prog_chk
    import spi_prog_pkg::*;
#(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned CNT_W    = 6,
    parameter int unsigned MAX_BITS = 56,
    parameter int unsigned CMD_ADDR = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              spi_cs_n,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic              busy,
    input logic [CNT_W-1:0]  cnt_cfg
);
    logic       prev_cs_n;
    logic       prev_sclk;
    logic [7:0] rise_cnt;
    logic       start_req;

    assign start_req = host_we && (host_addr == ADDR_W'(CMD_ADDR)) &&
                       host_wdata[START_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_cs_n <= 1'b1;
            prev_sclk <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            prev_cs_n <= spi_cs_n;
            prev_sclk <= spi_sclk;
            if (prev_cs_n && spi_cs_n)       rise_cnt <= '0;
            else if (spi_sclk && !prev_sclk) rise_cnt <= rise_cnt + 8'd1;
        end
    end

    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_mosi);

    assert_mosi_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !prev_cs_n && !$fell(spi_sclk)) |-> $stable(spi_mosi));

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !busy && (cnt_cfg != '0)) |=> (busy && !spi_cs_n));

    assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && spi_cs_n && (cnt_cfg == '0)) |=> spi_cs_n);

    assert_bit_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && !prev_cs_n) |-> (rise_cnt == 8'(cnt_cfg)));

    assert_bit_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rise_cnt) <= MAX_BITS);

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cnt_cfg));
endmodule

bind spi_prog_engine spi_prog_chk #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MAX_BITS (MAX_BITS),
    .CMD_ADDR (CMD_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .busy       (busy),
    .cnt_cfg    (cnt_cfg)
);

// File: tb/sim_spi_prog_engine.sv
`timescale 1ns/1ps
module sim_spi_prog_engine;
    localparam int HALF = 2;
    localparam int CMD  = 7;
    localparam int CNTA = 6;
    localparam int RXB  = 16;

    // each entry: bit count, transmit bytes 5..0, target reply stream
    localparam logic [109:0] VEC [5] = '{
        {6'd48, 48'hA53C0FF0817E, 56'hC35A9912345678},
        {6'd56, 48'h0123456789AB, 56'hFEDCBA98765432},
        {6'd8,  48'h9F0000000000, 56'hE7000000000000},
        {6'd17, 48'h05AA00000000, 56'h80FF0000000000},
        {6'd1,  48'h800000000000, 56'h80000000000000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    wire  [7:0] host_rdata;
    wire        cs_n, sclk, mosi, miso;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_prog_engine u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_cs_n(cs_n),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso)
    );

    // target model: reply stream moves on falling clock, output captured on rising clock
    logic [55:0] pat = '0;
    logic [55:0] cap = '0;
    int sidx = 0;
    int ccount = 0;
    always @(negedge cs_n) begin sidx = 0; cap = '0; ccount = 0; end
    always @(negedge sclk) if (cs_n === 1'b0) sidx++;
    always @(posedge sclk) if (cs_n === 1'b0) begin cap = {cap[54:0], mosi}; ccount++; end
    assign miso = (cs_n === 1'b0 && sidx < 56) ? pat[55 - sidx] : 1'b0;

    // mode monitor: output line may move only with a falling clock
    logic pm = 1'b0, ps = 1'b0, pc = 1'b1;
    int mviol = 0;
    int cs_low_cycles = 0;
    always begin
        @(posedge clk); #1;
        if (cs_n === 1'b0 && pc === 1'b0 && mosi !== pm && !(ps === 1'b1 && sclk === 1'b0)) mviol++;
        if (cs_n === 1'b0) cs_low_cycles++;
        pm = mosi; ps = sclk; pc = cs_n;
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr = 5'(a);
        #1 d = host_rdata;
    endtask

    // start a transaction and measure its length in clock edges
    task automatic run(input int n, input bit poke);
        int k;
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(CMD); host_wdata = 8'h04;
        @(posedge clk); #1;
        host_we = 1'b0;
        check("R4 busy after start", host_rdata[2], 1'b1);
        k = 0;
        while (k < 1000) begin
            @(posedge clk); #1;
            k++;
            if (poke && k == 5) begin host_we = 1'b1; host_addr = 5'd5; host_wdata = 8'hFF; end
            else if (poke && k == 6) begin host_addr = 5'(CNTA); host_wdata = 8'd3; end
            else if (poke && k == 7) begin host_addr = 5'(CMD); host_wdata = 8'h04; end
            else begin
                host_we = 1'b0; host_addr = 5'(CMD);
                if (!(poke && k == 8) && host_rdata[2] == 1'b0) break;
            end
        end
        check("R4 busy duration", k, 2 * HALF * n);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 cs_n", cs_n, 1'b1);
        check("R1 sclk", sclk, 1'b0);
        check("R1 mosi", mosi, 1'b0);
        rst_n = 1'b1;
        rd(CMD, d);  check("R1 busy", d, 8'h00);
        rd(5, d);    check("R1 tx5", d, 8'h00);
        rd(CNTA, d); check("R1 count", d, 8'h00);
        rd(RXB, d);  check("R1 rx0", d, 8'h00);
        rd(RXB + 9, d); check("R1 rx9", d, 8'h00);

        // table of transactions
        for (int v = 0; v < 5; v++) begin
            int n;
            logic [47:0] tx;
            logic [55:0] txs;
            logic [79:0] erx;
            n   = int'(VEC[v][109:104]);
            tx  = VEC[v][103:56];
            pat = VEC[v][55:0];
            for (int i = 0; i < 6; i++) wr(i, int'(tx[8*i +: 8]));
            wr(CNTA, n);
            rd(CNTA, d); check("R3 count readback", d, 8'(n));
            run(n, 1'b0);
            txs = {tx, 8'h00};
            check("R2 output stream", cap, txs >> (56 - n));
            check("R3 clock count", ccount, n);
            check("R9 cs_n high after", cs_n, 1'b1);
            erx = 80'(pat >> (56 - n));
            for (int i = 0; i < 10; i++) begin
                rd(RXB + i, d);
                check("R6 receive byte", d, erx[8*i +: 8]);
            end
        end
        check("R5 output moves only on falling clock", mviol, 0);

        // R3 clamp of the bit count
        wr(CNTA, 200); rd(CNTA, d); check("R3 clamp 200", d, 8'd56);
        wr(CNTA, 57);  rd(CNTA, d); check("R3 clamp 57", d, 8'd56);

        // R7 zero count
        wr(CNTA, 0);
        cs_low_cycles = 0;
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(CMD); host_wdata = 8'h04;
        @(posedge clk); #1;
        host_we = 1'b0;
        check("R7 busy stays 0", host_rdata[2], 1'b0);
        repeat (10) @(posedge clk);
        #1;
        check("R7 no chip select", cs_low_cycles, 0);

        // R8 writes during a transaction are ignored
        wr(5, 8'h3C);
        wr(CNTA, 16);
        pat = 56'h0;
        run(16, 1'b1);
        check("R8 clock count kept", ccount, 16);
        rd(5, d);    check("R8 tx5 kept", d, 8'h3C);
        rd(CNTA, d); check("R8 count kept", d, 8'd16);
        rd(CMD, d);  check("R8 no restart", d, 8'h00);
        check("R9 cs_n idle", cs_n, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule